// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A single-port synchronous static memory model with a pipelined read path and a late-write protocol. On each rising clock edge the block samples the address, the synchronous select, the power-down request, the write strobe and the per-lane write enables. A read returns its word from an output register one edge after the address was sampled. A write takes its data from the write-data input on the edge after its address and controls. It parks that data in a pending-write buffer, and the buffer drains into the storage array only when the next write's data arrives.

Reads always see the latest write in issue order. A read whose address matches the parked write takes the parked lanes and reads the remaining lanes from the array. This includes a read issued in the cycle right after the write. The bidirectional data path is modelled as separate in and out ports plus a drive-valid flag. An asynchronous output enable gates that flag and the read data. The word count is a parameter: the default is small for simulation and can be raised to the full 512K-word organisation.

Top module: `lw_sram`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `rvalid` is 0 and `rdata` is 0 (with `oe` high).
- R2: A read is accepted on edge t when `sel`=1, `pdown`=0 and `wr`=0. After edge t+1, `rdata` holds the word stored at that address, and `rvalid` is 1 while `oe` is 1.
- R3: A write is accepted on edge t when `sel`=1, `pdown`=0 and `wr`=1. Its data is the value on `wdata` at edge t+1, not the value at edge t.
- R4: Lane i is bits [9i+8:9i] of a word. With `wr_full`=1 a write updates both lanes, whatever `lane_en` holds. With `wr_full`=0, only lanes whose `lane_en[i]` is 1 are updated.
- R5: A read of the address held by the pending write returns that write's enabled lanes merged with the older array contents. This holds even when the read is issued in the cycle right after the write.
- R6: On an edge with `sel`=0 nothing is started. A write is discarded, `rvalid` is 0 after the following edge, and `rdata` keeps the last word read.
- R7: On an edge with `pdown`=1 nothing is started, in the same way as R6, whatever `sel` and `wr` hold.
- R8: `oe`=0 forces `rdata` to 0 and `rvalid` to 0 at once, without a clock edge. Raising `oe` again restores the registered word.
- R9: Any mix of back-to-back reads and writes returns, for every read, the value given by applying all earlier accepted writes in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, sampled each edge |
| sel | input | 1 | Synchronous select, 1 = start an operation |
| pdown | input | 1 | Synchronous power-down, 1 = no operation this edge |
| wr | input | 1 | 1 = write, 0 = read |
| wr_full | input | 1 | 1 = write every lane, ignoring `lane_en` |
| lane_en | input | LANES | Per-lane write enables used when `wr_full` is 0 |
| wdata | input | LANES*LANE_W | Write data, sampled one edge after its write |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | LANES*LANE_W | Registered read data, 0 when `oe` is 0 |
| rvalid | output | 1 | Output drive flag: a read result is present and `oe` is 1 |

## Verification
The assertions assume that `sel`, `pdown`, `wr` and `wr_full` are known (never X) at every sampled edge after reset. They also assume that an accepted operation is judged only by those control inputs, so the output and buffer behaviour two edges later follows from the controls alone. The stimulus changes inputs only at falling edges and always drives defined control values. It reads only addresses that were written first, so no unwritten array word ever reaches the output register. Output enable is toggled only between edges, which keeps its asynchronous effect separate from the registered pipeline.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Operation captured in the address/control stage.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES-1:0]          wmask,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Lane-masked write port.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  // Read port; the output stage registers it.
  assign rdata = mem[raddr];

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [LANES-1:0]          ld_mask,
  input  logic [LANES*LANE_W-1:0]   ld_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [LANES*LANE_W-1:0]   arr_data,
  output logic                      b_valid,
  output logic [ADDR_W-1:0]         b_addr,
  output logic [LANES-1:0]          b_mask,
  output logic [LANES*LANE_W-1:0]   b_data,
  output logic                      commit,
  output logic [LANES*LANE_W-1:0]   fwd_data
);
  logic hit;

  // A parked write drains exactly when the next write's data arrives.
  assign commit = load & b_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid <= 1'b0;
      b_addr  <= '0;
      b_mask  <= '0;
      b_data  <= '0;
    end else if (load) begin
      b_valid <= 1'b1;
      b_addr  <= ld_addr;
      b_mask  <= ld_mask;
      b_data  <= ld_data;
    end
  end

  assign hit = b_valid && (b_addr == rd_addr);

  // Per-lane merge of the parked write over the array word.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fwd_data[g*LANE_W +: LANE_W] = (hit && b_mask[g]) ? b_data[g*LANE_W +: LANE_W]
                                                             : arr_data[g*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/lw_sram_outreg.sv
module lw_sram_outreg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] dout_q,
  output logic              dvalid_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      dvalid_q <= load;
      if (load) dout_q <= din;
    end
  end

  // Output enable acts without a clock edge.
  assign rdata  = oe ? dout_q : '0;
  assign rvalid = oe & dvalid_q;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel,
  input  logic                    pdown,
  input  logic                    wr,
  input  logic                    wr_full,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               c_op;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_mask;

  logic              b_valid;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_mask;
  logic [DATA_W-1:0] b_data;
  logic              commit;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] fwd_data;
  logic [DATA_W-1:0] dout_q;
  logic              dvalid_q;

  // Address/control capture stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      c_op   <= OP_IDLE;
      c_addr <= '0;
      c_mask <= '0;
    end else begin
      if (!sel || pdown) c_op <= OP_IDLE;
      else               c_op <= wr ? OP_WRITE : OP_READ;
      c_addr <= addr;
      c_mask <= wr_full ? {LANES{1'b1}} : lane_en;
    end
  end

  lw_sram_array #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (b_addr),
    .wmask (b_mask),
    .wdata (b_data),
    .raddr (c_addr),
    .rdata (arr_data)
  );

  lw_sram_wbuf #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_wbuf (
    .clk      (clk),
    .rst      (rst),
    .load     (c_op == OP_WRITE),
    .ld_addr  (c_addr),
    .ld_mask  (c_mask),
    .ld_data  (wdata),
    .rd_addr  (c_addr),
    .arr_data (arr_data),
    .b_valid  (b_valid),
    .b_addr   (b_addr),
    .b_mask   (b_mask),
    .b_data   (b_data),
    .commit   (commit),
    .fwd_data (fwd_data)
  );

  lw_sram_outreg #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (c_op == OP_READ),
    .din      (fwd_data),
    .oe       (oe),
    .dout_q   (dout_q),
    .dvalid_q (dvalid_q),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              pdown,
  input logic              wr,
  input logic              wr_full,
  input logic              dvalid_q,
  input logic [DATA_W-1:0] dout_q,
  input logic              b_valid,
  input logic [ADDR_W-1:0] b_addr,
  input logic [LANES-1:0]  b_mask
);
  logic rd_in, wr_in, idle_in;
  assign rd_in   = sel && !pdown && !wr;
  assign wr_in   = sel && !pdown && wr;
  assign idle_in = !sel || pdown;

  // R2: an accepted read yields a valid output word two sampled edges later
  a_r2_read_valid: assert property (@(posedge clk) disable iff (rst)
    rd_in |=> ##1 dvalid_q);

  // R3: an accepted write leaves a parked entry behind
  a_r3_write_parked: assert property (@(posedge clk) disable iff (rst)
    wr_in |=> ##1 b_valid);

  // R4: a full-word write parks with every lane enabled
  a_r4_full_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_in && wr_full) |=> ##1 (b_mask == {LANES{1'b1}}));

  // R6: an idle edge produces no valid word and the output holds
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    idle_in |=> ##1 (!dvalid_q && $stable(dout_q)));

  // R7: power-down or deselect starts no write: the parked entry is unchanged
  a_r7_no_new_write: assert property (@(posedge clk) disable iff (rst)
    idle_in |=> ##1 ($stable(b_addr) && $stable(b_mask)));

endmodule

bind lw_sram lw_sram_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel      (sel),
  .pdown    (pdown),
  .wr       (wr),
  .wr_full  (wr_full),
  .dvalid_q (dvalid_q),
  .dout_q   (dout_q),
  .b_valid  (b_valid),
  .b_addr   (b_addr),
  .b_mask   (b_mask)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          sel = 1'b0;
  logic          pdown = 1'b0;
  logic          wr = 1'b0;
  logic          wr_full = 1'b0;
  logic [NL-1:0] lane_en = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe = 1'b1;
  logic [DW-1:0] rdata;
  logic          rvalid;

  lw_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .addr(addr), .sel(sel), .pdown(pdown), .wr(wr),
    .wr_full(wr_full), .lane_en(lane_en), .wdata(wdata), .oe(oe),
    .rdata(rdata), .rvalid(rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int            due;
    logic          vld;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  logic [DW-1:0] ref_mem [16];
  logic [DW-1:0] pend = '0;
  logic [DW-1:0] last_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic got_v, input logic [DW-1:0] got_d,
                       input logic exp_v, input logic [DW-1:0] exp_d);
    checks++;
    if (got_v !== exp_v || got_d !== exp_d) begin
      errors++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, got_v, got_d, exp_v, exp_d);
    end
  endtask

  // Driver: one slot per call; kind 0 idle, 1 read, 2 write.
  task automatic do_op(input int kind, input int a, input logic full, input logic [NL-1:0] le,
                       input logic [DW-1:0] d, input logic s, input logic pd, input string tag);
    exp_t e;
    logic acc;
    @(negedge clk);
    addr    = AW'(a);
    sel     = (kind == 0) ? 1'b0 : s;
    pdown   = pd;
    wr      = (kind == 2);
    wr_full = full;
    lane_en = le;
    wdata   = pend;
    acc     = (kind != 0) && s && !pd;
    if (acc && kind == 2) begin
      for (int i = 0; i < NL; i++)
        if (full || le[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
      pend = d;
    end
    e.due = cyc + 2;
    e.tag = tag;
    if (acc && kind == 1) begin
      e.vld   = 1'b1;
      e.data  = ref_mem[a];
      last_rd = ref_mem[a];
    end else begin
      e.vld  = 1'b0;
      e.data = last_rd;
    end
    sb.push_back(e);
  endtask

  // Monitor: compares the output against the scoreboard between edges.
  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, rvalid, rdata, e.vld, e.data);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: rvalid=%0b rdata=%h expected run to end", rvalid, rdata);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", rvalid, rdata, 1'b0, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", rvalid, rdata, 1'b0, '0);

    // R4 / R9: back-to-back full writes to fill the working range
    for (int a = 0; a < 16; a++)
      do_op(2, a, 1'b1, 2'b00, {a[8:0] ^ 9'h155, a[8:0] + 9'h0A3}, 1'b1, 1'b0, "R9");
    // R5: first read hits the still-parked write of address 15
    do_op(1, 15, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R5");
    for (int a = 0; a < 16; a++) do_op(1, a, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R2");

    // R5: lane-0 write followed immediately by a read of the same word
    do_op(2, 3, 1'b0, 2'b01, 18'h2_AB_CD, 1'b1, 1'b0, "R4");
    do_op(1, 3, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R5");
    do_op(0, 0, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R6");
    do_op(1, 3, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R5");
    // R3: the value on wdata during the write slot itself must not be taken
    do_op(2, 4, 1'b1, 2'b00, 18'h1_23_45, 1'b1, 1'b0, "R3");
    do_op(1, 3, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R9");
    do_op(1, 4, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R3");
    // R4: full flag overrides zero lane enables; lane-1-only write
    do_op(2, 5, 1'b1, 2'b00, 18'h0_F0_0F, 1'b1, 1'b0, "R4");
    do_op(2, 6, 1'b0, 2'b10, 18'h3_FF_FF, 1'b1, 1'b0, "R4");
    do_op(1, 5, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R4");
    do_op(1, 6, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R4");

    // R6: deselected write and read start nothing
    do_op(2, 7, 1'b1, 2'b00, 18'h0_00_11, 1'b0, 1'b0, "R6");
    do_op(1, 7, 1'b0, 2'b00, '0, 1'b0, 1'b0, "R6");
    do_op(1, 7, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R6");
    // R7: power-down write and read start nothing
    do_op(2, 8, 1'b1, 2'b00, 18'h0_00_22, 1'b1, 1'b1, "R7");
    do_op(1, 8, 1'b0, 2'b00, '0, 1'b1, 1'b1, "R7");
    do_op(1, 8, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R7");

    // R9: pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op((lfsr[1:0] == 2'd3) ? 2 : int'(lfsr[1:0]), int'(lfsr[5:2]), lfsr[6], lfsr[8:7],
            {lfsr[15:0], lfsr[3:2]}, lfsr[11:9] != 3'd0, lfsr[14:12] == 3'd7, "R9");
    end

    // R8: asynchronous output enable
    do_op(1, 2, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R2");
    do_op(0, 0, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R6");
    @(negedge clk);
    #2;
    oe = 1'b0;
    #1;
    check("R8", rvalid, rdata, 1'b0, '0);
    oe = 1'b1;
    #1;
    check("R8", rvalid, rdata, 1'b1, ref_mem[2]);

    for (int n = 0; n < 4; n++) do_op(0, 0, 1'b0, 2'b00, '0, 1'b1, 1'b0, "R6");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: rvalid=%0b rdata=%h expected %0d pending results drained", rvalid, rdata, sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule